// File: doc/BRIEF.md
# Byte-Lane Common-IO Memory Port

This block is a synchronous memory array reached through a single bidirectional data bus. The bus is split into byte lanes, and each lane carries eight data bits and one parity bit. A write is a late write: the address, command and lane mask are taken on one rising edge, and the data is taken from the shared bus on the next rising edge. No write strobe pulse is needed. Each write updates only the lanes whose select bit was set together with the write command. The parity bits are stored and returned like any other bit; the block does not compute or check them.

A read returns the whole word on the bus two edges after the command. The port drives the bus only when a read result is due, the active-low output enable is low, and the bus is not in a write data phase. A new command may be issued in every cycle, including the cycle in which write data is captured.

Top module: `bytelane_sram_port`

## Requirements
- R1: When `sel` and `wr_en` are high at a rising edge, the word at `addr` is updated in exactly those lanes whose `lane_we` bit is 1. Lane i occupies bus bits [9i+8:9i].
- R2: Lanes whose `lane_we` bit is 0 during a write keep their previous nine bits unchanged.
- R3: Bit 8 of each lane (the parity bit) is stored and read back exactly like the eight data bits of that lane.
- R4: Write data is sampled from `dq` on the rising edge after the command edge. The lane mask, however, is the one presented with the command; `lane_we` in the data cycle has no effect.
- R5: For a read command taken at edge k, the word is driven on `dq` after edge k+1 and stays there until edge k+2. Back-to-back reads produce their words in consecutive cycles.
- R6: While `oe_n` is 1, the port does not drive `dq`.
- R7: During the write data phase (the cycle after a write command edge), the port does not drive `dq`, whatever `oe_n` is and even when a read result is due in that cycle.
- R8: A command issued in the write data-capture cycle is accepted. A read of the same address issued in that cycle returns the newly written data.
- R9: When `sel` is 0 at an edge, nothing happens: no lane is written and no read result is produced.
- R10: An active-low `rst_n` clears the command and read pipeline asynchronously. A write or read that is in flight when reset is asserted is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| sel | input | 1 | Command valid / port select, active high |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| lane_we | input | LANES | Per-lane write select, sampled with the command |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, active low |
| dq | inout | LANES*(DATA_W+1) | Shared data and parity bus |

## Verification
The hardest situation to reach from the ports is a read result that falls due in the same cycle as a write data phase. In that cycle the port must stay off the bus while the bench is driving it. The stimulus issues a read and then, on the very next edge, a write. It uses two bit patterns whose wired combination differs from the write pattern, so any drive from the port corrupts the captured word and the bus value. A second tricky case issues a read in the data-capture cycle of a write to the same address.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } port_op_e;
endpackage

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    output port_op_e          op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  mask_q
);
    typedef struct packed {
        port_op_e          op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  mask;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.addr = addr;
        if (!sel) begin
            s_d.op   = OP_IDLE;
            s_d.mask = '0;
        end else if (wr_en) begin
            s_d.op   = OP_WR;
            s_d.mask = lane_we;
        end else begin
            s_d.op   = OP_RD;
            s_d.mask = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign op_q   = s_q.op;
    assign addr_q = s_q.addr;
    assign mask_q = s_q.mask;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wr_word,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_wr[g]) mem[addr] <= wr_word[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_port_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_e          op,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              oe_n,
    output logic              drv_en,
    output logic [WORD_W-1:0] out_word
);
    typedef struct packed {
        logic              due;
        logic [WORD_W-1:0] data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.due = (op == OP_RD);
        if (op == OP_RD) o_d.data = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    // A write data phase always wins over a due read result.
    assign drv_en   = o_q.due && !oe_n && (op != OP_WR);
    assign out_word = o_q.data;
endmodule

// File: rtl/bytelane_sram_port.sv
module bytelane_sram_port
    import sram_port_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel,
    input  logic                           wr_en,
    input  logic [LANES-1:0]               lane_we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           oe_n,
    inout  wire  [LANES*(DATA_W+1)-1:0]    dq
);
    localparam int LANE_W = DATA_W + 1;
    localparam int WORD_W = LANES * LANE_W;

    port_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  mask_q;
    logic [LANES-1:0]  lane_wr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] out_word;
    logic              drv_en;

    sram_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (wr_en),
        .addr    (addr),
        .lane_we (lane_we),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .mask_q  (mask_q)
    );

    assign lane_wr = (op_q == OP_WR) ? mask_q : '0;

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .lane_wr (lane_wr),
        .addr    (addr_q),
        .wr_word (dq),
        .rd_word (rd_word)
    );

    sram_bus_ctrl #(.WORD_W(WORD_W)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_q),
        .rd_word  (rd_word),
        .oe_n     (oe_n),
        .drv_en   (drv_en),
        .out_word (out_word)
    );

    assign dq = drv_en ? out_word : {WORD_W{1'bz}};
endmodule

// File: rtl/sram_port_checker.sv
module sram_port_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             wr_en,
    input logic [LANES-1:0] lane_we,
    input logic             oe_n,
    input logic             drv_en,
    input logic [LANES-1:0] lane_wr
);
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        p_lane_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
            lane_wr[g] |-> $past(sel && wr_en && lane_we[g]));
    end

    p_mask_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && wr_en) |-> ((lane_wr & ~$past(lane_we)) == '0));

    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> $past(sel && !wr_en, 2));

    p_oe_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drv_en);

    p_write_phase_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && wr_en) |-> !drv_en);

    p_idle_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel) |-> (lane_wr == '0));
endmodule

bind bytelane_sram_port sram_port_checker #(.LANES(LANES)) u_chk (.*);

// File: tb/bytelane_sram_port_tb.sv
module bytelane_sram_port_tb;
    localparam int LANES = 4;
    localparam int AW    = 6;
    localparam int WW    = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic wr_en = 1'b0;
    logic [LANES-1:0] lane_we = '0;
    logic [AW-1:0] addr = '0;
    logic oe_n = 1'b0;
    logic tb_en = 1'b0;
    logic [WW-1:0] tb_val = '0;
    wire  [WW-1:0] dq;

    assign dq = tb_en ? tb_val : {WW{1'bz}};

    bytelane_sram_port #(.LANES(LANES), .DATA_W(8), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
        .lane_we(lane_we), .addr(addr), .oe_n(oe_n), .dq(dq)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [WW-1:0] model [64];

    // Vector: {op 2b (1=write,2=read), addr 6b, mask 4b, data 36b}
    localparam logic [47:0] VEC [14] = '{
        {2'd1, 6'd5,  4'hF, 36'h1_2345_6789},
        {2'd2, 6'd5,  4'h0, 36'h0},
        {2'd1, 6'd5,  4'h5, 36'hF_FFFF_FFFF},
        {2'd2, 6'd5,  4'h0, 36'h0},
        {2'd1, 6'd5,  4'hA, 36'h0_0000_0000},
        {2'd2, 6'd5,  4'h0, 36'h0},
        {2'd1, 6'd9,  4'hF, 36'hA_5A5A_5A5A},
        {2'd1, 6'd9,  4'h0, 36'h0_0000_0000},
        {2'd2, 6'd9,  4'h0, 36'h0},
        {2'd1, 6'd9,  4'h8, 36'h3_C000_0000},
        {2'd2, 6'd9,  4'h0, 36'h0},
        {2'd1, 6'd12, 4'hF, 36'h8_0402_0100},
        {2'd2, 6'd12, 4'h0, 36'h0},
        {2'd2, 6'd5,  4'h0, 36'h0}
    };

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic check_eq(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ne(string req, logic [WW-1:0] act, logic [WW-1:0] notv);
        total++;
        if (act === notv) begin
            bad++;
            $display("FAIL %s actual=%h expected=not %h", req, act, notv);
        end
    endtask

    task automatic idle_cmd();
        sel = 1'b0; wr_en = 1'b0; lane_we = '0;
    endtask

    task automatic model_write(logic [AW-1:0] a, logic [LANES-1:0] m, logic [WW-1:0] d);
        for (int i = 0; i < LANES; i++)
            if (m[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
    endtask

    // R4: mask presented with the command; lane_we cleared in data cycle.
    task automatic do_write(logic [AW-1:0] a, logic [LANES-1:0] m, logic [WW-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; lane_we = m;
        @(negedge clk);
        idle_cmd();
        tb_en = 1'b1; tb_val = d;
        @(negedge clk);
        tb_en = 1'b0;
        model_write(a, m, d);
    endtask

    task automatic do_read(logic [AW-1:0] a, output logic [WW-1:0] got);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = a;
        @(negedge clk);
        idle_cmd();
        @(negedge clk);
        got = dq;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [WW-1:0] got;
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Zero all used addresses so the model is defined.
        for (int a = 0; a < 32; a++) do_write(a[AW-1:0], 4'hF, '0);

        // Table walk: R1, R2, R3, R4 (mask with command), R5
        for (int v = 0; v < 14; v++) begin
            if (VEC[v][47:46] == 2'd1)
                do_write(VEC[v][45:40], VEC[v][39:36], VEC[v][35:0]);
            else begin
                do_read(VEC[v][45:40], got);
                check_eq($sformatf("R1/R2/R3 vec%0d", v), got, model[VEC[v][45:40]]);
            end
        end

        // R6: oe_n high keeps the port off the bus
        do_write(6'd20, 4'hF, 36'hA_AAAA_AAAA);
        oe_n = 1'b1;
        do_read(6'd20, got);
        check_ne("R6 oe_n high no drive", got, 36'hA_AAAA_AAAA);
        oe_n = 1'b0;
        do_read(6'd20, got);
        check_eq("R6 oe_n low drives", got, 36'hA_AAAA_AAAA);

        // R7: read then write: result slot collides with write data phase
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = 6'd20;
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = 6'd22; lane_we = 4'hF;
        @(negedge clk);
        idle_cmd();
        tb_en = 1'b1; tb_val = 36'h5_5555_5555;
        #1;
        check_eq("R7 bus holds write data only", dq, 36'h5_5555_5555);
        @(negedge clk);
        tb_en = 1'b0;
        model_write(6'd22, 4'hF, 36'h5_5555_5555);
        do_read(6'd22, got);
        check_eq("R7 write intact", got, 36'h5_5555_5555);

        // R8: read of same address issued in the data-capture cycle
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = 6'd23; lane_we = 4'hF;
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; lane_we = '0; addr = 6'd23;
        tb_en = 1'b1; tb_val = 36'h6_1234_ABCD;
        @(negedge clk);
        tb_en = 1'b0; idle_cmd();
        @(negedge clk);
        check_eq("R8 read after write", dq, 36'h6_1234_ABCD);
        model_write(6'd23, 4'hF, 36'h6_1234_ABCD);

        // R5: back-to-back reads in consecutive cycles
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = 6'd5;
        @(negedge clk);
        addr = 6'd9;
        @(negedge clk);
        idle_cmd();
        check_eq("R5 first of pair", dq, model[5]);
        @(negedge clk);
        check_eq("R5 second of pair", dq, model[9]);
        @(negedge clk);
        check_ne("R5 held only one cycle", dq, model[9]);

        // R9: deselected write is ignored
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b1; addr = 6'd22; lane_we = 4'hF;
        @(negedge clk);
        idle_cmd();
        tb_en = 1'b1; tb_val = 36'h0_0F0F_0F0F;
        @(negedge clk);
        tb_en = 1'b0;
        do_read(6'd22, got);
        check_eq("R9 deselect no write", got, model[22]);

        // R10: reset drops an in-flight read
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = 6'd20;
        @(negedge clk);
        idle_cmd();
        rst_n = 1'b0;
        @(negedge clk);
        check_ne("R10 read dropped", dq, 36'hA_AAAA_AAAA);
        rst_n = 1'b1;

        // R10: reset drops an in-flight write
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = 6'd20; lane_we = 4'hF;
        @(negedge clk);
        idle_cmd();
        rst_n = 1'b0;
        tb_en = 1'b1; tb_val = 36'h1_1111_1111;
        @(negedge clk);
        tb_en = 1'b0; rst_n = 1'b1;
        do_read(6'd20, got);
        check_eq("R10 write dropped", got, 36'hA_AAAA_AAAA);

        done = 1'b1;
        summary();
    end
endmodule